// File: doc/BRIEF.md
# PLL Bandwidth and Multiplier Register Block

This block is the software-visible register file in front of a PLL clock generator. Over a byte-wide register bus it holds three things. The first is the bandwidth control: an automatic-mode enable and an acquisition/tracking selection. The second is a lock indication passed through from the PLL core. The third is the 12-bit feedback-divider multiplier, which is split across a high byte register and a low byte register. The block drives the effective acquisition/tracking mode and the full multiplier value to the PLL core.

In manual mode, software selects acquisition or tracking directly. In automatic mode, the core's bandwidth controller decides the mode, and the mode bit only reports that decision. The last mode value written by software in manual operation is held in a shadow register. It becomes the effective mode again as soon as automatic mode is turned off. Reads are combinational from the address bus. Writes take effect on the clock edge at which the write strobe is sampled.

Register map, as the addresses used on `addr`:
- 0: control register. Bit 2 is the automatic enable. Bit 1 is the lock flag. Bit 0 is the mode bit (1 = tracking, 0 = acquisition). Bits 7..3 read 0.
- 1: multiplier high register. Bits 3..0 hold multiplier bits 11..8. Bits 7..4 read 0.
- 2: multiplier low register. Bits 7..0 hold multiplier bits 7..0.
- 3: unused.

Top module: `pllcfg_regs`

## Requirements
- R1: After synchronous reset, automatic mode is off, the mode is acquisition (`mode_trk` = 0), and `mul_val` is 0x002. A read of the control register returns 0x00, a read of the high register returns 0x00, and a read of the low register returns 0x02.
- R2: With automatic mode off, a control-register write sets the effective mode from bit 0. The value appears on `mode_trk` and in read bit 0 from the next cycle on.
- R3: With automatic mode on, `mode_trk` and control read bit 0 follow `core_trk` in the same cycle.
- R4: A control-register write made while automatic mode is on does not change the shadowed manual mode value.
- R5: When automatic mode is turned off, the effective mode becomes the last value written to bit 0 while automatic mode was off. After reset, that value is 0.
- R6: Control read bit 1 equals `core_lock` while automatic mode is on, and reads 0 while it is off. Writing 1 to bit 1 has no effect.
- R7: A write to address 1 loads `wdata[3:0]` into multiplier bits 11..8. A read of address 1 returns those four bits in bits 3..0, with bits 7..4 reading 0.
- R8: A write to address 2 loads `wdata[7:0]` into multiplier bits 7..0, and a read of address 2 returns them.
- R9: A read of address 3 returns 0. A write to address 3 changes neither the multiplier, the mode nor the automatic enable.
- R10: Bits 7..3 of the control register always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 2 | Register address for reads and writes |
| wr_en | input | 1 | Write strobe, sampled at the clock edge |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Combinational read data for `addr` |
| core_lock | input | 1 | Lock indication from the PLL core |
| core_trk | input | 1 | Mode chosen by the automatic bandwidth controller (1 = tracking) |
| mode_trk | output | 1 | Effective mode to the core (1 = tracking) |
| mul_val | output | 12 | Feedback-divider multiplier |

## Verification
The bench writes a tracking value in manual mode, then enables automatic mode. While automatic mode is on, it writes the opposite value and disables automatic mode again. A design that updated the shadow during automatic operation would come back in acquisition instead of tracking. It also toggles `core_trk` and `core_lock` in both modes. A design that leaked the lock flag in manual mode, or that let hardware drive the mode while automatic mode is off, would disagree with the reference model on the next compared clock. Writes of all-ones to the high register and to the unused address expose a multiplier that keeps the high register's upper nibble, or that decodes the unused address as a real register.

// File: rtl/pllcfg_pkg.sv
package pllcfg_pkg;

    localparam int DATA_W = 8;
    localparam int ADDR_W = 2;
    localparam int MUL_W  = 12;
    localparam int HI_W   = MUL_W - DATA_W;

    localparam logic [MUL_W-1:0] MUL_RESET = 12'h002;

    // control register bit positions
    localparam int CB_TRK  = 0;
    localparam int CB_LOCK = 1;
    localparam int CB_AUTO = 2;

    typedef enum logic [ADDR_W-1:0] {
        ADR_CTRL = 2'd0,
        ADR_MULH = 2'd1,
        ADR_MULL = 2'd2,
        ADR_NONE = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic auto_on;
        logic lock_vis;
        logic trk;
    } ctrl_view_t;

    function automatic logic [DATA_W-1:0] pack_ctrl(input ctrl_view_t v);
        logic [DATA_W-1:0] r;
        r = '0;
        r[CB_AUTO] = v.auto_on;
        r[CB_LOCK] = v.lock_vis;
        r[CB_TRK]  = v.trk;
        return r;
    endfunction

endpackage

// File: rtl/pllcfg_bwctl.sv
module pllcfg_bwctl
    import pllcfg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ctrl_wr,
    input  logic wr_auto,
    input  logic wr_trk,
    input  logic core_trk,
    input  logic core_lock,
    output logic auto_q,
    output logic man_q,
    output ctrl_view_t view
);

    logic eff_trk;

    always_ff @(posedge clk) begin
        if (rst) begin
            auto_q <= 1'b0;
            man_q  <= 1'b0;
        end else if (ctrl_wr) begin
            auto_q <= wr_auto;
            // shadow only accepts software writes while manual
            if (!auto_q) begin
                man_q <= wr_trk;
            end
        end
    end

    always_comb begin
        eff_trk       = auto_q ? core_trk : man_q;
        view.auto_on  = auto_q;
        view.lock_vis = auto_q & core_lock;
        view.trk      = eff_trk;
    end

endmodule

// File: rtl/pllcfg_mulreg.sv
module pllcfg_mulreg
    import pllcfg_pkg::*;
#(
    parameter int W_DATA = DATA_W,
    parameter int W_MUL  = MUL_W,
    parameter logic [W_MUL-1:0] RST_VAL = MUL_RESET
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_hi,
    input  logic              wr_lo,
    input  logic [W_DATA-1:0] wdata,
    output logic [W_MUL-1:0]  mul_val
);

    localparam int W_HI = W_MUL - W_DATA;

    logic [W_HI-1:0]   hi_q;
    logic [W_DATA-1:0] lo_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q <= RST_VAL[W_MUL-1:W_DATA];
        end else if (wr_hi) begin
            hi_q <= wdata[W_HI-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q <= RST_VAL[W_DATA-1:0];
        end else if (wr_lo) begin
            lo_q <= wdata;
        end
    end

    assign mul_val = {hi_q, lo_q};

endmodule

// File: rtl/pllcfg_rdmux.sv
module pllcfg_rdmux
    import pllcfg_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  ctrl_view_t        view,
    input  logic [MUL_W-1:0]  mul_val,
    output logic [DATA_W-1:0] rdata
);

    always_comb begin
        rdata = '0;
        unique case (reg_addr_e'(addr))
            ADR_CTRL: rdata = pack_ctrl(view);
            ADR_MULH: rdata[HI_W-1:0] = mul_val[MUL_W-1:DATA_W];
            ADR_MULL: rdata = mul_val[DATA_W-1:0];
            default:  rdata = '0;
        endcase
    end

endmodule

// File: rtl/pllcfg_regs.sv
module pllcfg_regs
    import pllcfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              core_lock,
    input  logic              core_trk,
    output logic              mode_trk,
    output logic [MUL_W-1:0]  mul_val
);

    logic       ctrl_wr;
    logic       wr_hi;
    logic       wr_lo;
    logic       auto_q;
    logic       man_q;
    ctrl_view_t view;

    assign ctrl_wr = wr_en && (reg_addr_e'(addr) == ADR_CTRL);
    assign wr_hi   = wr_en && (reg_addr_e'(addr) == ADR_MULH);
    assign wr_lo   = wr_en && (reg_addr_e'(addr) == ADR_MULL);

    pllcfg_bwctl u_bw (
        .clk      (clk),
        .rst      (rst),
        .ctrl_wr  (ctrl_wr),
        .wr_auto  (wdata[CB_AUTO]),
        .wr_trk   (wdata[CB_TRK]),
        .core_trk (core_trk),
        .core_lock(core_lock),
        .auto_q   (auto_q),
        .man_q    (man_q),
        .view     (view)
    );

    pllcfg_mulreg #(
        .W_DATA (DATA_W),
        .W_MUL  (MUL_W),
        .RST_VAL(MUL_RESET)
    ) u_mul (
        .clk    (clk),
        .rst    (rst),
        .wr_hi  (wr_hi),
        .wr_lo  (wr_lo),
        .wdata  (wdata),
        .mul_val(mul_val)
    );

    pllcfg_rdmux u_rd (
        .addr   (addr),
        .view   (view),
        .mul_val(mul_val),
        .rdata  (rdata)
    );

    assign mode_trk = view.trk;

endmodule

// File: rtl/pllcfg_regs_chk.sv
module pllcfg_regs_chk
    import pllcfg_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] addr,
    input logic              wr_en,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W-1:0] rdata,
    input logic [MUL_W-1:0]  mul_val,
    input logic              auto_q,
    input logic              man_q
);

    // R4
    shadow_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (auto_q && wr_en && addr == 2'd0) |=> $stable(man_q));

    // R6
    lock_hidden_chk: assert property (@(posedge clk) disable iff (rst)
        (!auto_q && addr == 2'd0) |-> !rdata[1]);

    // R7
    mul_hi_load_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == 2'd1) |=> mul_val[11:8] == $past(wdata[3:0]));

    // R8
    mul_lo_load_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == 2'd2) |=> mul_val[7:0] == $past(wdata));

    // R9
    mul_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && (addr == 2'd1 || addr == 2'd2)) |=> $stable(mul_val));

    // R10
    ctrl_pad_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (addr == 2'd0) |-> rdata[7:3] == 5'd0);

endmodule

bind pllcfg_regs pllcfg_regs_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .addr   (addr),
    .wr_en  (wr_en),
    .wdata  (wdata),
    .rdata  (rdata),
    .mul_val(mul_val),
    .auto_q (auto_q),
    .man_q  (man_q)
);

// File: tb/pllcfg_regs_test.sv
module pllcfg_regs_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  addr = 2'd0;
    logic        wr_en = 1'b0;
    logic [7:0]  wdata = 8'd0;
    logic [7:0]  rdata;
    logic        core_lock = 1'b0;
    logic        core_trk = 1'b0;
    logic        mode_trk;
    logic [11:0] mul_val;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // reference state
    bit        m_auto = 0;
    bit        m_man  = 0;
    int        m_mul  = 2;

    always #5 clk = ~clk;

    pllcfg_regs uut (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wdata(wdata),
        .rdata(rdata), .core_lock(core_lock), .core_trk(core_trk),
        .mode_trk(mode_trk), .mul_val(mul_val)
    );

    function automatic int exp_read(input int a);
        case (a)
            0: return (int'(m_auto) << 2) | (int'(m_auto && core_lock) << 1)
                      | int'(m_auto ? core_trk : m_man);
            1: return (m_mul >> 8) & 15;
            2: return m_mul & 255;
            default: return 0;
        endcase
    endfunction

    task automatic expect_eq(input int got, input int exp, input string tag);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s got=%0h expected=%0h", tag, got, exp);
        end
    endtask

    // compare every clock against the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            expect_eq(int'(mode_trk), int'(m_auto ? core_trk : m_man),
                      m_auto ? "R3 mode" : "R2 mode");
            expect_eq(int'(mul_val), m_mul, "R7/R8 mul_val");
            case (addr)
                2'd0: expect_eq(int'(rdata), exp_read(0), "R6 ctrl read");
                2'd1: expect_eq(int'(rdata), exp_read(1), "R7 hi read");
                2'd2: expect_eq(int'(rdata), exp_read(2), "R8 lo read");
                default: expect_eq(int'(rdata), 0, "R9 empty read");
            endcase
        end
    end

    task automatic wr(input int a, input int d);
        @(posedge clk); #1;
        addr = 2'(a); wdata = 8'(d); wr_en = 1'b1;
        @(posedge clk);
        case (a)
            0: begin
                if (!m_auto) m_man = d[0];
                m_auto = d[2];
            end
            1: m_mul = (m_mul & 255) | ((d & 15) << 8);
            2: m_mul = (m_mul & 'hF00) | (d & 255);
            default: ;
        endcase
        #1 wr_en = 1'b0;
    endtask

    task automatic rd_at(input int a, output int v);
        @(posedge clk); #1;
        addr = 2'(a);
        #2 v = int'(rdata);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
    endtask

    initial begin
        int v;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R1 reset state
        expect_eq(int'(mul_val), 2, "R1 mul reset");
        expect_eq(int'(mode_trk), 0, "R1 mode reset");
        rd_at(0, v); expect_eq(v, 0, "R1 ctrl reset");
        rd_at(1, v); expect_eq(v, 0, "R1 hi reset");
        rd_at(2, v); expect_eq(v, 2, "R1 lo reset");

        // R2 manual mode, hardware inputs ignored
        core_trk = 1'b1; core_lock = 1'b1;
        wr(0, 'h01); idle(1);
        expect_eq(int'(mode_trk), 1, "R2 tracking");
        wr(0, 'h00); idle(1);
        expect_eq(int'(mode_trk), 0, "R2 acquisition");
        // R6 lock hidden when manual, write 1 ignored
        wr(0, 'h02); rd_at(0, v);
        expect_eq(v, 0, "R6 lock hidden manual");

        // R10 pad bits
        wr(0, 'hF9); rd_at(0, v);
        expect_eq(v & 'hF8, 0, "R10 pad bits");
        wr(0, 'h01);

        // R3 automatic mode follows core
        wr(0, 'h05);
        core_trk = 1'b0; idle(2);
        expect_eq(int'(mode_trk), 0, "R3 follow core 0");
        core_trk = 1'b1; idle(2);
        expect_eq(int'(mode_trk), 1, "R3 follow core 1");
        rd_at(0, v); expect_eq(v, 'h07, "R6 lock visible auto");
        core_lock = 1'b0; idle(1);
        rd_at(0, v); expect_eq(v, 'h05, "R6 unlocked auto");

        // R4 write in auto mode does not touch shadow
        core_trk = 1'b0;
        wr(0, 'h04); idle(1);
        expect_eq(int'(mode_trk), 0, "R4 auto ignores write");
        // R5 leaving auto restores shadow (1)
        wr(0, 'h00); idle(1);
        expect_eq(int'(mode_trk), 1, "R5 shadow restored");
        core_trk = 1'b0; core_lock = 1'b1; idle(2);

        // R7 / R8 multiplier
        wr(1, 'hFA); rd_at(1, v); expect_eq(v, 'h0A, "R7 hi readback");
        wr(2, 'h5C); rd_at(2, v); expect_eq(v, 'h5C, "R8 lo readback");
        expect_eq(int'(mul_val), 'hA5C, "R7 full value");
        wr(1, 'h03); wr(2, 'hFF);
        expect_eq(int'(mul_val), 'h3FF, "R8 full value");

        // R9 unused address
        wr(3, 'hFF); rd_at(3, v);
        expect_eq(v, 0, "R9 read zero");
        expect_eq(int'(mul_val), 'h3FF, "R9 mul unchanged");
        expect_eq(int'(mode_trk), 1, "R9 mode unchanged");
        rd_at(0, v); expect_eq(v, 'h01, "R9 auto unchanged");

        // reset again
        #1 rst = 1'b1; @(posedge clk);
        m_auto = 0; m_man = 0; m_mul = 2;
        #1 rst = 1'b0; idle(1);
        expect_eq(int'(mul_val), 2, "R1 mul after second reset");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog got=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule